// File: doc/BRIEF.md
# DVFS Frequency-Voltage Transition Sequencer

This block moves a processor core from its present operating point, a frequency code and a voltage code, to a requested target pair. It does not write the target in one step. It walks there in three ordered phases. First it raises the supply in programmable steps, then adds a small overshoot. Next it moves the frequency in bounded steps measured on the oscillator scale. Last it settles the voltage at its final value. A higher supply uses a lower voltage code.

Each move is a write of a 64-bit control word to the clock and supply controller. After each write the sequencer polls a 64-bit status word until its pending flag clears, and it takes the new present operating point from that word. It then waits a settle time counted in microsecond ticks before it issues the next write. Software or a power manager pulses `start` with the target and the configuration fields. It then watches `busy`, `done` and `err`.

The control interface is valid/ready. The sequencer raises `ctl_valid` with a complete word. It holds both the valid and the word unchanged until the cycle in which `ctl_ready` is high, which completes the write. The controller may hold `ctl_ready` low for any number of cycles. The status word is a plain input sampled every cycle. Its pending flag must read high from the cycle after a write is accepted until that write has taken effect.

Top module: `dvfs_walk_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `ctl_valid` are all low.
- R2: If status bit 31 (pending) is high when `start` is taken, no control write occurs, `err` goes high and `busy` stays low.
- R3: If the status frequency code (bits 5:0) and voltage code (bits 36:32) already equal the target, `done` pulses and no control write occurs.
- R4: While the present voltage code is above the target code, each write keeps the present frequency code and sets the voltage code to present minus 2^`cfg_vstep_exp`, clamped at 0.
- R5: After R4, up to `cfg_overshoot` further writes each lower the voltage code by 1. This stops early once the code reaches 0.
- R6: Frequency moves use the oscillator value v(f) = 8 + 2f for f < 8, else f. While |v(target) − v(present)| > 2 an intermediate code is written. Going up it is present + 2 if present > 6, else v(present) + 2. Going down it is present − 2. One write of the exact target frequency code follows.
- R7: The control word carries the frequency code in bits 5:0, the voltage code in bits 12:8, a constant 1 in bit 16 and zero in all other bits below 32. Bits 63:32 hold the lock count. The count is `cfg_lock` × 200 for frequency writes and 1 for voltage writes.
- R8: If the present voltage code still differs from the target after the frequency phase, exactly one write of the target voltage code is made.
- R9: After a write's pending flag clears, the next write waits at least 20 × `cfg_vsettle` ticks after a voltage write, or 10 × 2^`cfg_fsettle_exp` ticks after a frequency write.
- R10: If pending stays high for POLL_LIMIT consecutive polls, the transition stops with no further writes, `err` goes high and `done` does not pulse.
- R11: While `ctl_valid` is high and `ctl_ready` is low, `ctl_valid` stays high and `ctl_word` stays unchanged on the next cycle.
- R12: `start` is ignored while `busy` is high, and the target is captured only when `start` is taken. `done` is high for exactly one cycle. `err` stays high until the next `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transition (taken only when idle) |
| tgt_fid | input | 6 | Target frequency code |
| tgt_vid | input | 5 | Target voltage code (lower is higher voltage) |
| cfg_vstep_exp | input | 2 | Voltage raise step exponent |
| cfg_overshoot | input | 2 | Number of extra single voltage steps |
| cfg_fsettle_exp | input | 2 | Frequency settle exponent (10 × 2^n ticks) |
| cfg_vsettle | input | 5 | Voltage settle multiplier (20 × n ticks) |
| cfg_lock | input | 7 | PLL lock time, scaled by 200 into the count field |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ctl_valid | output | 1 | Control word valid |
| ctl_ready | input | 1 | Controller accepts the control word |
| ctl_word | output | 64 | Control word |
| sts_word | input | 64 | Status word from the controller |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Transition aborted, held until next start |

## Verification
A wrong phase, a wrong step counter or a wrong present-code register shows at the control port on the very next write. That write carries a voltage code, frequency code or lock count different from the sequence the requirements predict, so the bench compares every accepted word in order. A settle timer that expires early shows as a next write issued after too few ticks, and the bench measures this between consecutive accepted writes. A poll counter that never saturates shows as a hung `busy` or a missing `err` within the poll limit. A skipped or extra final write shows at the end as a wrong write count or a `done` that is missing or doubled.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;
  localparam int FID_W = 6;
  localparam int VID_W = 5;
  localparam int VCO_W = FID_W + 1;
  localparam int CNT_W = 32;
  localparam int CTL_W = 64;

  // Field positions on the control and status words (decoded by the controller)
  localparam int CW_FID_LSB  = 0;
  localparam int CW_VID_LSB  = 8;
  localparam int CW_ONE_BIT  = 16;
  localparam int CW_CNT_LSB  = 32;
  localparam int SW_FID_LSB  = 0;
  localparam int SW_PEND_BIT = 31;
  localparam int SW_VID_LSB  = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_WRITE, S_POLL, S_SETTLE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_RAISE, PH_OVER, PH_FREQ, PH_FINAL
  } seq_phase_e;

  typedef enum logic [1:0] {
    A_WRITE, A_NEXT, A_FINISH
  } plan_act_e;

  // Frequency code mapped onto the oscillator scale
  function automatic logic [VCO_W-1:0] vco_of(input logic [FID_W-1:0] f);
    if (f < FID_W'(8)) return VCO_W'(8) + (VCO_W'(f) << 1);
    else               return VCO_W'(f);
  endfunction
endpackage

// File: rtl/dvfs_step_plan.sv
module dvfs_step_plan
  import dvfs_seq_pkg::*;
(
  input  seq_phase_e       phase,
  input  logic [FID_W-1:0] cur_fid,
  input  logic [VID_W-1:0] cur_vid,
  input  logic [FID_W-1:0] tgt_fid,
  input  logic [VID_W-1:0] tgt_vid,
  input  logic [1:0]       vstep_exp,
  input  logic [1:0]       ovr_left,
  input  logic             fin_done,
  output plan_act_e        act,
  output logic [FID_W-1:0] wr_fid,
  output logic [VID_W-1:0] wr_vid,
  output logic             wr_freq
);
  logic [VID_W-1:0] step;
  logic [VCO_W-1:0] vc, vt, gap;
  logic             far, going_up;

  always_comb begin
    step     = VID_W'(1) << vstep_exp;
    vc       = vco_of(cur_fid);
    vt       = vco_of(tgt_fid);
    gap      = (vt >= vc) ? (vt - vc) : (vc - vt);
    far      = gap > VCO_W'(2);
    going_up = tgt_fid > cur_fid;

    act     = A_NEXT;
    wr_fid  = cur_fid;
    wr_vid  = cur_vid;
    wr_freq = 1'b0;

    case (phase)
      PH_RAISE: begin
        if (cur_vid > tgt_vid) begin
          act    = A_WRITE;
          wr_vid = (cur_vid > step) ? (cur_vid - step) : '0;
        end
      end
      PH_OVER: begin
        if (ovr_left != 2'd0 && cur_vid != '0) begin
          act    = A_WRITE;
          wr_vid = cur_vid - VID_W'(1);
        end
      end
      PH_FREQ: begin
        if (cur_fid != tgt_fid) begin
          act     = A_WRITE;
          wr_freq = 1'b1;
          if (!far)
            wr_fid = tgt_fid;
          else if (!going_up)
            wr_fid = cur_fid - FID_W'(2);
          else if (cur_fid > FID_W'(6))
            wr_fid = cur_fid + FID_W'(2);
          else
            wr_fid = FID_W'(vc + VCO_W'(2));
        end
      end
      default: begin
        if (!fin_done && cur_vid != tgt_vid) begin
          act    = A_WRITE;
          wr_vid = tgt_vid;
        end else begin
          act = A_FINISH;
        end
      end
    endcase
  end
endmodule

// File: rtl/dvfs_tick_timer.sv
module dvfs_tick_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      remain <= '0;
    else if (load)                   remain <= load_val;
    else if (tick && remain != '0)   remain <= remain - W'(1);
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/dvfs_poll_guard.sv
module dvfs_poll_guard #(
  parameter int LIMIT = 100000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_limit
);
  logic [W-1:0] polls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   polls <= '0;
    else if (clear)               polls <= '0;
    else if (step && !at_limit)   polls <= polls + W'(1);
  end

  assign at_limit = (polls >= W'(LIMIT - 1));
endmodule

// File: rtl/dvfs_walk_seq.sv
module dvfs_walk_seq
  import dvfs_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 100000,
  parameter int VST_UNIT   = 20,
  parameter int IRT_BASE   = 10,
  parameter int LOCK_MULT  = 200,
  parameter int DLY_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [5:0]       tgt_fid,
  input  logic [4:0]       tgt_vid,
  input  logic [1:0]       cfg_vstep_exp,
  input  logic [1:0]       cfg_overshoot,
  input  logic [1:0]       cfg_fsettle_exp,
  input  logic [4:0]       cfg_vsettle,
  input  logic [6:0]       cfg_lock,
  input  logic             us_tick,
  output logic             ctl_valid,
  input  logic             ctl_ready,
  output logic [63:0]      ctl_word,
  input  logic [63:0]      sts_word,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  seq_state_e       state;
  seq_phase_e       phase;
  logic [FID_W-1:0] cur_fid, tgt_fid_q;
  logic [VID_W-1:0] cur_vid, tgt_vid_q;
  logic [1:0]       vstep_q, ovr_q, fset_q, ovr_left;
  logic [4:0]       vset_q;
  logic [6:0]       lock_q;
  logic             fin_done, last_freq;
  logic [CTL_W-1:0] word_q, wr_word;

  // Status decode
  logic             sts_pend;
  logic [FID_W-1:0] sts_fid;
  logic [VID_W-1:0] sts_vid;
  logic             unused_sts;
  assign sts_pend   = sts_word[SW_PEND_BIT];
  assign sts_fid    = sts_word[SW_FID_LSB +: FID_W];
  assign sts_vid    = sts_word[SW_VID_LSB +: VID_W];
  assign unused_sts = ^{sts_word[63:37], sts_word[30:6]};

  // Next-move planner
  plan_act_e        act;
  logic [FID_W-1:0] plan_fid;
  logic [VID_W-1:0] plan_vid;
  logic             plan_freq;

  dvfs_step_plan u_plan (
    .phase    (phase),
    .cur_fid  (cur_fid),
    .cur_vid  (cur_vid),
    .tgt_fid  (tgt_fid_q),
    .tgt_vid  (tgt_vid_q),
    .vstep_exp(vstep_q),
    .ovr_left (ovr_left),
    .fin_done (fin_done),
    .act      (act),
    .wr_fid   (plan_fid),
    .wr_vid   (plan_vid),
    .wr_freq  (plan_freq)
  );

  // Control word assembly
  logic [CNT_W-1:0] lock_cnt;
  always_comb begin
    lock_cnt = plan_freq ? (CNT_W'(lock_q) * CNT_W'(LOCK_MULT)) : CNT_W'(1);
    wr_word  = '0;
    wr_word[CW_FID_LSB +: FID_W] = plan_fid;
    wr_word[CW_VID_LSB +: VID_W] = plan_vid;
    wr_word[CW_ONE_BIT]          = 1'b1;
    wr_word[CW_CNT_LSB +: CNT_W] = lock_cnt;
  end

  // Settle timer
  logic             tmr_load, tmr_expired;
  logic [DLY_W-1:0] settle_val;
  assign tmr_load   = (state == S_POLL) && !sts_pend;
  assign settle_val = last_freq ? (DLY_W'(IRT_BASE) << fset_q)
                                : DLY_W'(VST_UNIT * int'(vset_q));

  dvfs_tick_timer #(.W(DLY_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(settle_val),
    .tick    (us_tick),
    .expired (tmr_expired)
  );

  // Pending-wait poll limit
  logic poll_at_limit;
  dvfs_poll_guard #(.LIMIT(POLL_LIMIT), .W(POLL_W)) u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state == S_WRITE),
    .step    ((state == S_POLL) && sts_pend),
    .at_limit(poll_at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      phase     <= PH_RAISE;
      cur_fid   <= '0;
      cur_vid   <= '0;
      tgt_fid_q <= '0;
      tgt_vid_q <= '0;
      vstep_q   <= '0;
      ovr_q     <= '0;
      fset_q    <= '0;
      vset_q    <= '0;
      lock_q    <= '0;
      ovr_left  <= '0;
      fin_done  <= 1'b0;
      last_freq <= 1'b0;
      word_q    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            tgt_fid_q <= tgt_fid;
            tgt_vid_q <= tgt_vid;
            vstep_q   <= cfg_vstep_exp;
            ovr_q     <= cfg_overshoot;
            fset_q    <= cfg_fsettle_exp;
            vset_q    <= cfg_vsettle;
            lock_q    <= cfg_lock;
            err       <= 1'b0;
            if (sts_pend) begin
              err <= 1'b1;
            end else if (sts_fid == tgt_fid && sts_vid == tgt_vid) begin
              done <= 1'b1;
            end else begin
              cur_fid  <= sts_fid;
              cur_vid  <= sts_vid;
              phase    <= PH_RAISE;
              fin_done <= 1'b0;
              state    <= S_PLAN;
            end
          end
        end
        S_PLAN: begin
          case (act)
            A_WRITE: begin
              word_q    <= wr_word;
              last_freq <= plan_freq;
              if (phase == PH_OVER)  ovr_left <= ovr_left - 2'd1;
              if (phase == PH_FINAL) fin_done <= 1'b1;
              state <= S_WRITE;
            end
            A_NEXT: begin
              case (phase)
                PH_RAISE: begin phase <= PH_OVER; ovr_left <= ovr_q; end
                PH_OVER:  phase <= PH_FREQ;
                default:  phase <= PH_FINAL;
              endcase
            end
            default: begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        S_WRITE: begin
          if (ctl_ready) state <= S_POLL;
        end
        S_POLL: begin
          if (!sts_pend) begin
            cur_fid <= sts_fid;
            cur_vid <= sts_vid;
            state   <= S_SETTLE;
          end else if (poll_at_limit) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: begin
          if (tmr_expired) state <= S_PLAN;
        end
      endcase
    end
  end

  assign ctl_valid = (state == S_WRITE);
  assign ctl_word  = word_q;
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/dvfs_walk_seq_chk.sv
module dvfs_walk_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        ctl_valid,
  input logic        ctl_ready,
  input logic [63:0] ctl_word
);
  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && !ctl_ready |=> ctl_valid && $stable(ctl_word));

  p_word_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> ctl_word[16] && ctl_word[31:17] == 15'd0 &&
                  ctl_word[15:13] == 3'd0 && ctl_word[7:6] == 2'd0);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);

  p_done_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err && !busy);
endmodule

bind dvfs_walk_seq dvfs_walk_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .ctl_valid(ctl_valid),
  .ctl_ready(ctl_ready),
  .ctl_word (ctl_word)
);

// File: tb/dvfs_walk_seq_test.sv
module dvfs_walk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS      = 64;
  localparam int LOCK       = 3;
  localparam int VST        = 1;
  localparam int IRT        = 0;
  localparam int NV         = 6;
  // cur fid, cur vid, tgt fid, tgt vid, vstep exp, overshoot
  localparam int VEC [NV][6] = '{
    '{ 2, 10, 14,  4, 1, 2},
    '{14,  4,  0, 12, 0, 1},
    '{ 0,  8, 20,  8, 2, 0},
    '{10,  3, 10,  1, 2, 3},
    '{ 9,  2,  9,  6, 0, 0},
    '{ 7,  5, 12,  5, 0, 0}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [5:0] tgt_fid = 0;
  logic [4:0] tgt_vid = 0;
  logic [1:0] vstep = 0, ovr = 0;
  logic us_tick, ctl_valid, ctl_ready, busy, done, err;
  logic [63:0] ctl_word, sts_word;

  // controller model controls
  logic pre_load = 0, pre_pend = 0, stuck = 0, bp_en = 0;
  logic [5:0] pre_fid = 0;
  logic [4:0] pre_vid = 0;
  logic [5:0] m_fid, n_fid;
  logic [4:0] m_vid, n_vid;
  logic m_pend, rdy_q, tick_q;
  logic [1:0] lat;
  int wn, done_cnt, tick_total;
  logic [63:0] wlog [32];
  int wstamp [32];

  int n_tests = 0, n_fail = 0;
  logic [63:0] exp_w [32];
  bit exp_f [32];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvfs_walk_seq #(.POLL_LIMIT(POLLS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_fid(tgt_fid), .tgt_vid(tgt_vid),
    .cfg_vstep_exp(vstep), .cfg_overshoot(ovr), .cfg_fsettle_exp(2'(IRT)),
    .cfg_vsettle(5'(VST)), .cfg_lock(7'(LOCK)), .us_tick(us_tick),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_word(ctl_word),
    .sts_word(sts_word), .busy(busy), .done(done), .err(err));

  assign sts_word  = {27'd0, m_vid, m_pend, 25'd0, m_fid};
  assign ctl_ready = rdy_q;
  assign us_tick   = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 0; tick_total <= 0; rdy_q <= 1;
    end else begin
      tick_q <= ~tick_q;
      if (tick_q) tick_total <= tick_total + 1;
      rdy_q <= bp_en ? ~rdy_q : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fid <= 0; m_vid <= 0; m_pend <= 0; lat <= 0; wn <= 0; done_cnt <= 0;
      n_fid <= 0; n_vid <= 0;
    end else if (pre_load) begin
      m_fid <= pre_fid; m_vid <= pre_vid; m_pend <= pre_pend; wn <= 0; done_cnt <= 0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      if (ctl_valid && ctl_ready) begin
        if (wn < 32) begin wlog[wn] <= ctl_word; wstamp[wn] <= tick_total; end
        wn <= wn + 1; m_pend <= 1; lat <= 3;
        n_fid <= ctl_word[5:0]; n_vid <= ctl_word[12:8];
      end else if (m_pend && !stuck) begin
        if (lat == 0) begin m_fid <= n_fid; m_vid <= n_vid; m_pend <= 0; end
        else lat <= lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int vco(input int f);
    return (f < 8) ? 8 + 2 * f : f;
  endfunction

  task automatic push(input int f, input int v, input bit fr);
    logic [31:0] c;
    c = fr ? 32'(LOCK * 200) : 32'd1;
    exp_w[exp_n] = {c, 15'd0, 1'b1, 3'd0, 5'(v), 2'd0, 6'(f)};
    exp_f[exp_n] = fr;
    exp_n++;
  endtask

  // expected write sequence, built from R4..R8
  task automatic ref_walk(input int cf, input int cv, input int tf, input int tv,
                          input int mv, input int ro);
    int nv, nf;
    exp_n = 0;
    if (cf == tf && cv == tv) return;
    while (cv > tv) begin
      nv = cv - (1 << mv); if (nv < 0) nv = 0;
      push(cf, nv, 0); cv = nv;
    end
    for (int r = ro; r > 0 && cv > 0; r--) begin push(cf, cv - 1, 0); cv = cv - 1; end
    if (cf != tf) begin
      while ((vco(tf) > vco(cf) ? vco(tf) - vco(cf) : vco(cf) - vco(tf)) > 2) begin
        if (tf > cf) nf = (cf > 6) ? cf + 2 : vco(cf) + 2;
        else         nf = cf - 2;
        push(nf, cv, 1); cf = nf;
      end
      push(tf, cv, 1); cf = tf;
    end
    if (cv != tv) push(cf, tv, 0);
  endtask

  task automatic preset(input int f, input int v, input bit p);
    @(negedge clk);
    pre_fid = 6'(f); pre_vid = 5'(v); pre_pend = p; pre_load = 1;
    @(negedge clk);
    pre_load = 0;
  endtask

  task automatic pulse_start(input int f, input int v, input int mv, input int ro);
    tgt_fid = 6'(f); tgt_vid = 5'(v); vstep = 2'(mv); ovr = 2'(ro);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare_log(input string tag);
    chk(wn == exp_n, tag, "write count", wn, exp_n);
    for (int i = 0; i < exp_n && i < wn; i++)
      chk(wlog[i] == exp_w[i], tag, $sformatf("word %0d", i), wlog[i], exp_w[i]);
    for (int i = 1; i < exp_n && i < wn; i++) begin
      int need;
      need = exp_f[i-1] ? (10 << IRT) : 20 * VST;
      chk(wstamp[i] - wstamp[i-1] >= need, "R9", $sformatf("settle before %0d", i),
          wstamp[i] - wstamp[i-1], need);
    end
    chk(done_cnt == 1, tag, "done cycles", done_cnt, 1);
    chk(err == 0, tag, "err", err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(err == 0, "R1", "err", err, 0);
    chk(ctl_valid == 0, "R1", "ctl_valid", ctl_valid, 0);

    // R4 R5 R6 R7 R8 R11: table walk, back-pressure on odd rows
    for (int k = 0; k < NV; k++) begin
      bp_en = k[0];
      preset(VEC[k][0], VEC[k][1], 0);
      ref_walk(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4], VEC[k][5]);
      pulse_start(VEC[k][2], VEC[k][3], VEC[k][4], VEC[k][5]);
      wait_idle();
      compare_log($sformatf("R4-R8 row%0d", k));
    end
    bp_en = 0;

    // R2: pending already set at start
    preset(5, 9, 1);
    pulse_start(9, 3, 0, 0);
    chk(busy == 0, "R2", "busy", busy, 0);
    @(negedge clk);
    chk(err == 1, "R2", "err", err, 1);
    chk(wn == 0, "R2", "writes", wn, 0);
    chk(done_cnt == 0, "R2", "done", done_cnt, 0);

    // R3: already at target
    preset(12, 6, 0);
    pulse_start(12, 6, 1, 1);
    @(negedge clk);
    chk(wn == 0, "R3", "writes", wn, 0);
    chk(done_cnt == 1, "R3", "done cycles", done_cnt, 1);
    chk(err == 0, "R3", "err cleared", err, 0);

    // R10: pending never clears
    stuck = 1;
    preset(5, 10, 0);
    pulse_start(5, 6, 0, 0);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(err == 1, "R10", "err", err, 1);
    chk(wn == 1, "R10", "writes", wn, 1);
    chk(done_cnt == 0, "R10", "done", done_cnt, 0);
    chk(busy == 0, "R10", "busy", busy, 0);
    stuck = 0;

    // R12: err held, then cleared by next start
    preset(5, 10, 0);
    chk(err == 1, "R12", "err held", err, 1);
    pulse_start(5, 10, 0, 0);
    @(negedge clk);
    chk(err == 0, "R12", "err after start", err, 0);
    chk(done_cnt == 1, "R12", "done", done_cnt, 1);

    // R12: start ignored while busy, target captured at start
    preset(VEC[0][0], VEC[0][1], 0);
    ref_walk(VEC[0][0], VEC[0][1], VEC[0][2], VEC[0][3], VEC[0][4], VEC[0][5]);
    pulse_start(VEC[0][2], VEC[0][3], VEC[0][4], VEC[0][5]);
    repeat (5) @(negedge clk);
    chk(busy == 1, "R12", "busy mid-run", busy, 1);
    pulse_start(0, 0, 3, 0);
    wait_idle();
    compare_log("R12 restart-ignored");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule